// File: doc/BRIEF.md
# Lattice Message Recovery Encoder

This block turns two 256-coefficient polynomials into a 256-bit message. Both polynomials sit in separate synchronous-read memories that return data one cycle after the address is presented. Once the block is started, it walks the coefficient index from 0 upward and drives the same index on both read ports. For each index it subtracts the second coefficient from the first, reduces the result modulo 3329, and decides one bit by comparing that value against fixed thresholds.

Each bit is stored at its own index of a 256-bit register, with coefficient 0 in bit 0. Every coefficient takes exactly two clock cycles. In the first cycle the address is presented. In the second cycle the returned data is used to write the bit. After the last coefficient the block raises a done flag and keeps the message steady until it is started again.

Top module: `lmr_msg_recover`

## Requirements
- R1: While reset is held, and after it is released, `msg` is 0, `done` is 0, and both addresses are 0.
- R2: A start pulse accepted while the block is not processing clears `done` and `msg` and restarts at index 0. In the cycle after the start edge both addresses read 0.
- R3: Each index is presented on the address ports for exactly two consecutive cycles. `done` is first seen 512 clock edges after the edge that accepted the start.
- R4: The value used for index i is w = (a[i] − b[i]) mod 3329. When a[i] < b[i], 3329 is added to the difference, so w always lies in [0, 3328].
- R5: The bit for index i is 1 exactly when 832 < w ≤ 2496. Otherwise it is 0. The edge cases are: w = 832 gives 0, 833 gives 1, 2496 gives 1, 2497 gives 0, 0 gives 0, and 3328 gives 0.
- R6: The bit for coefficient index i is written to `msg[i]`, so packing is LSB-first. At most one bit of `msg` changes on any edge without a start pulse.
- R7: `done` rises on the same edge that writes bit 255. After that, `done` stays high and `msg` stays unchanged until the next accepted start.
- R8: A start pulse that arrives while the block is processing is ignored. The index sequence, the cycle count and the final message are unaffected.
- R9: Both read ports always carry the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle start request |
| a_addr | output | 8 | Read address into the minuend memory |
| a_rdata | input | 12 | Minuend coefficient, valid one cycle after `a_addr` |
| b_addr | output | 8 | Read address into the subtrahend memory |
| b_rdata | input | 12 | Subtrahend coefficient, valid one cycle after `b_addr` |
| msg | output | 256 | Packed message, bit i from coefficient i |
| done | output | 1 | High once all 256 bits are written; held until the next start |

## Verification
The properties assume that both memories hold fully reduced coefficients below 3329 and that neither memory changes while a pass is running. The bench writes its memories only while the block is idle, and it draws every coefficient modulo 3329. The properties also assume that read data follows the address by exactly one cycle. The bench models each memory as a single registered read, so this holds. Start pulses last one cycle and are driven away from the clock edge. Some of them deliberately land mid-pass, in each of the two phases.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    // Default geometry of the recovery pass.
    localparam int LMR_N_COEF = 256;
    localparam int LMR_COEF_W = 12;
    localparam int LMR_Q      = 3329;

    // Two-phase read per coefficient.
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } lmr_phase_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } lmr_state_e;

    typedef struct packed {
        lmr_state_e st;
        lmr_phase_e ph;
    } lmr_ctl_t;

endpackage

// File: rtl/lmr_ctrl.sv
module lmr_ctrl
    import lmr_pkg::*;
#(
    parameter int N_COEF = LMR_N_COEF,
    localparam int IDX_W = $clog2(N_COEF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             data_ph,
    output logic             wr_en,
    output logic             clear,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_COEF - 1);

    lmr_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st <= ST_IDLE;
            ctl_q.ph <= PH_ADDR;
            idx      <= '0;
        end else if (start && ctl_q.st != ST_RUN) begin
            ctl_q.st <= ST_RUN;
            ctl_q.ph <= PH_ADDR;
            idx      <= '0;
        end else if (ctl_q.st == ST_RUN) begin
            if (ctl_q.ph == PH_ADDR) begin
                ctl_q.ph <= PH_DATA;
            end else begin
                ctl_q.ph <= PH_ADDR;
                if (idx == LAST_IDX) begin
                    ctl_q.st <= ST_DONE;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy    = (ctl_q.st == ST_RUN);
        done    = (ctl_q.st == ST_DONE);
        data_ph = (ctl_q.ph == PH_DATA);
        wr_en   = busy && data_ph;
        clear   = start && !busy;
    end

endmodule

// File: rtl/lmr_modsub.sv
module lmr_modsub #(
    parameter int COEF_W = 12,
    parameter int Q      = 3329
) (
    input  logic [COEF_W-1:0] a,
    input  logic [COEF_W-1:0] b,
    output logic [COEF_W-1:0] w
);

    localparam logic [COEF_W-1:0] Q_V = COEF_W'(Q);

    logic [COEF_W:0] diff;

    always_comb begin
        diff = {1'b0, a} - {1'b0, b};
        // Borrow out means a < b: fold back into [0, Q).
        if (diff[COEF_W]) begin
            w = diff[COEF_W-1:0] + Q_V;
        end else begin
            w = diff[COEF_W-1:0];
        end
    end

endmodule

// File: rtl/lmr_compress.sv
module lmr_compress #(
    parameter int COEF_W = 12,
    parameter int Q      = 3329
) (
    input  logic [COEF_W-1:0] w,
    output logic              bit_o
);

    // Quarter and three-quarter points of the modulus, rounded down.
    localparam logic [COEF_W-1:0] LO_V = COEF_W'(Q / 4);
    localparam logic [COEF_W-1:0] HI_V = COEF_W'((3 * Q) / 4);

    assign bit_o = (w > LO_V) && (w <= HI_V);

endmodule

// File: rtl/lmr_msg_recover.sv
module lmr_msg_recover
    import lmr_pkg::*;
#(
    parameter int N_COEF = LMR_N_COEF,
    parameter int COEF_W = LMR_COEF_W,
    parameter int Q      = LMR_Q,
    localparam int IDX_W = $clog2(N_COEF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [IDX_W-1:0]  a_addr,
    input  logic [COEF_W-1:0] a_rdata,
    output logic [IDX_W-1:0]  b_addr,
    input  logic [COEF_W-1:0] b_rdata,
    output logic [N_COEF-1:0] msg,
    output logic              done
);

    logic [IDX_W-1:0]  idx;
    logic              busy;
    logic              data_ph;
    logic              wr_en;
    logic              clear;
    logic [COEF_W-1:0] w_val;
    logic              w_bit;

    lmr_ctrl #(
        .N_COEF (N_COEF)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .idx     (idx),
        .busy    (busy),
        .data_ph (data_ph),
        .wr_en   (wr_en),
        .clear   (clear),
        .done    (done)
    );

    lmr_modsub #(
        .COEF_W (COEF_W),
        .Q      (Q)
    ) u_modsub (
        .a (a_rdata),
        .b (b_rdata),
        .w (w_val)
    );

    lmr_compress #(
        .COEF_W (COEF_W),
        .Q      (Q)
    ) u_compress (
        .w     (w_val),
        .bit_o (w_bit)
    );

    assign a_addr = idx;
    assign b_addr = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg <= '0;
        end else if (clear) begin
            msg <= '0;
        end else if (wr_en) begin
            msg[idx] <= w_bit;
        end
    end

endmodule

// File: rtl/lmr_msg_recover_chk.sv
module lmr_msg_recover_chk #(
    parameter int N_COEF = 256,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              data_ph,
    input logic [IDX_W-1:0]  a_addr,
    input logic [IDX_W-1:0]  b_addr,
    input logic [N_COEF-1:0] msg,
    input logic              done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_COEF - 1);

    AST_PORTS_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        a_addr == b_addr); // R9

    AST_ADDR_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
        busy && !data_ph |=> busy && data_ph && $stable(a_addr)); // R3

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && start && data_ph && a_addr != LAST_IDX
        |=> busy && a_addr == $past(a_addr) + 1'b1); // R8

    AST_ONE_BIT_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
        !start |=> $countones(msg ^ $past(msg)) <= 1); // R6

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(msg)); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(done && busy)); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy && !done && msg == '0 && a_addr == '0); // R2

endmodule

bind lmr_msg_recover lmr_msg_recover_chk #(
    .N_COEF (N_COEF),
    .IDX_W  (IDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .data_ph (data_ph),
    .a_addr  (a_addr),
    .b_addr  (b_addr),
    .msg     (msg),
    .done    (done)
);

// File: tb/lmr_msg_recover_bench.sv
module lmr_msg_recover_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 256;
    localparam int QM = 3329;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [7:0]   a_addr, b_addr;
    logic [11:0]  a_rdata = '0, b_rdata = '0;
    logic [255:0] msg;
    logic         done;

    logic [11:0] mem_a [N];
    logic [11:0] mem_b [N];

    int compared   = 0;
    int mismatched = 0;
    bit cmp_en     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        a_rdata <= mem_a[a_addr];
        b_rdata <= mem_b[b_addr];
    end

    lmr_msg_recover u_lmr_msg_recover (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .a_addr  (a_addr),
        .a_rdata (a_rdata),
        .b_addr  (b_addr),
        .b_rdata (b_rdata),
        .msg     (msg),
        .done    (done)
    );

    // Behavioural rule for one coefficient (R4, R5).
    function automatic bit ref_bit(int a, int b);
        int w;
        w = a - b;
        if (w < 0) w = w + QM;
        return (w > 832) && (w <= 2496);
    endfunction

    function automatic logic [255:0] ref_msg();
        logic [255:0] r;
        for (int i = 0; i < N; i++) r[i] = ref_bit(int'(mem_a[i]), int'(mem_b[i]));
        return r;
    endfunction

    // Cycle-level expectation.
    bit           m_busy = 0;
    bit           m_done = 0;
    int           m_idx  = 0;
    int           m_ph   = 0;
    logic [255:0] m_msg  = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_idx = 0; m_ph = 0; m_msg = '0;
        end else if (start && !m_busy) begin
            m_busy = 1; m_done = 0; m_idx = 0; m_ph = 0; m_msg = '0;
        end else if (m_busy) begin
            if (m_ph == 0) begin
                m_ph = 1;
            end else begin
                m_msg[m_idx] = ref_bit(int'(mem_a[m_idx]), int'(mem_b[m_idx]));
                m_ph = 0;
                if (m_idx == N - 1) begin
                    m_busy = 0;
                    m_done = 1;
                end else begin
                    m_idx++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk(done == m_done, "R7", "done per cycle", 256'(done), 256'(m_done));
            chk(msg == m_msg, "R6", "msg per cycle", msg, m_msg);
            chk(a_addr == b_addr, "R9", "port addresses", 256'(a_addr), 256'(b_addr));
            if (m_busy)
                chk(a_addr == 8'(m_idx), "R3", "address per cycle",
                    256'(a_addr), 256'(m_idx));
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", '0, '1);
        finish_run();
    end

    // One full pass; poke > 0 drives an extra start at that cycle count (R8).
    task automatic run_pass(input string tag, input int poke);
        int cnt;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(msg == '0, "R2", {tag, " msg cleared"}, msg, '0);
        chk(!done && a_addr == 8'd0, "R2", {tag, " restart at index 0"},
            256'({done, a_addr}), '0);
        cnt = 0;
        while (!done) begin
            start = (poke > 0 && cnt == poke);
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        chk(cnt == 2 * N, "R3", {tag, " edges to done"}, 256'(cnt), 256'(2 * N));
        chk(msg == ref_msg(), "R4 R5 R6", {tag, " packed message"}, msg, ref_msg());
        repeat (4) @(negedge clk);
        chk(done && msg == ref_msg(), "R7", {tag, " held after done"}, msg, ref_msg());
    endtask

    task automatic fill_boundary(input bit wrap);
        int wl [8] = '{832, 833, 2496, 2497, 0, 3328, 1, 1664};
        for (int i = 0; i < N; i++) begin
            int b;
            b = wrap ? int'($urandom % QM) : 0;
            mem_b[i] = 12'(b);
            mem_a[i] = 12'((wl[(i + i / 8) % 8] + b) % QM);
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < N; i++) begin
            mem_a[i] = 12'($urandom % QM);
            mem_b[i] = 12'($urandom % QM);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mem_a[i] = '0;
            mem_b[i] = '0;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(msg == '0 && !done && a_addr == 8'd0, "R1", "state under reset",
            msg, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(msg == '0 && !done && a_addr == 8'd0 && b_addr == 8'd0, "R1",
            "state after reset", msg, '0);
        cmp_en = 1'b1;

        // R5 thresholds without and with the modular wrap (R4).
        fill_boundary(1'b0);
        run_pass("R5 thresholds a-b>=0", 0);
        fill_boundary(1'b1);
        run_pass("R4 thresholds with wrap", 0);

        // R6 bit positions: a single set bit at each end.
        fill_random();
        for (int i = 0; i < N; i++) begin
            mem_a[i] = mem_b[i];
        end
        mem_a[0] = 12'((int'(mem_b[0]) + 1664) % QM);
        run_pass("R6 lsb only", 0);
        chk(msg == 256'd1, "R6", "bit 0 position", msg, 256'd1);
        mem_a[0] = mem_b[0];
        mem_b[N-1] = 12'((int'(mem_a[N-1]) + QM - 1000) % QM);
        run_pass("R6 msb only", 0);
        chk(msg == (256'd1 << 255), "R6", "bit 255 position", msg, 256'd1 << 255);

        // Random polynomials.
        for (int k = 0; k < 3; k++) begin
            fill_random();
            run_pass("R4 R5 random", 0);
        end

        // Extra start during each phase while busy.
        fill_random();
        run_pass("R8 start in address phase", 100);
        fill_random();
        run_pass("R8 start in data phase", 201);

        finish_run();
    end

endmodule